// File: doc/BRIEF.md
# Watchdog and interval timer

This block is an 8-bit up-counter steered by one control/status byte. The byte sets the counting rate, starts or stops the count, and picks what an overflow does. In interval mode an overflow raises a level interrupt request. In watchdog mode it raises either a one-cycle reset request or a level non-maskable interrupt request. Software that keeps the watchdog alive reloads the counter before it wraps.

Both registers sit on a small register bus. A write is accepted only when the upper byte of the 16-bit write data carries the access key. The counting rate comes from a set of divided-clock tap inputs. A standby input clears the run-time fields and keeps the rate selection.

Top module: `wdt_timer`

## Requirements
- R1: After `rst_n` is low, the control byte reads 0x08 (bit 3 always reads 1, every other field is 0), the counter reads 0, and all three request outputs are low.
- R2: A write with `bus_wdata[15:8]` different from 0xA5 leaves both registers unchanged. A write with 0xA5 loads `bus_wdata[7:0]`.
- R3: The overflow flag (control bit 7) clears only when a 0 is written to bit 7 by the first write that follows a read of the control byte showing the flag as 1. Writing 1 to bit 7, or writing 0 without such a read, leaves the flag set.
- R4: Clock-select code k (control bits 2..0) makes the counter advance once per rising edge of `tap_in[k]`. With the bench taps, this is one step every 2^(k+1) clock cycles.
- R5: While the enable (control bit 5) is 0, the counter reads 0 and holds there. A counter write is then ignored.
- R6: A counter wrap from 0xFF to 0x00 sets the overflow flag. In interval mode (control bit 6 = 0), `irq_ovf` then stays high until the flag is cleared, and `nmi_req` and `rst_req` stay low.
- R7: In watchdog mode with control bit 4 = 0, an overflow holds `nmi_req` high until the flag is cleared, and `irq_ovf` stays low.
- R8: In watchdog mode with control bit 4 = 1, an overflow produces a single one-cycle `rst_req` pulse, and `nmi_req` and `irq_ovf` stay low.
- R9: One cycle of `standby` clears the flag, the mode, the enable, control bit 4 and the counter, and keeps the clock-select bits.
- R10: While the counter is enabled, a keyed write to the counter register (`bus_sel` = 1) loads the counter with `bus_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| standby | input | 1 | Standby entry; clears the run-time fields |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | Register select: 0 control byte, 1 counter |
| bus_wdata | input | 16 | Key in [15:8], data in [7:0] |
| bus_rdata | output | 8 | Read data of the selected register |
| tap_in | input | 8 | Divided-clock taps, one per clock-select code |
| irq_ovf | output | 1 | Interval overflow interrupt request (level) |
| nmi_req | output | 1 | Watchdog non-maskable interrupt request (level) |
| rst_req | output | 1 | Watchdog reset request (one-cycle pulse) |

## Verification
A wrong flag or armed state shows at the ports within one bus access. A request output either stays high after a legal clear or drops after an illegal one, and the next control read shows the wrong bit 7. A wrong rate or a bad tap edge detector shows up as a counter difference other than the expected one across a 64-cycle window. Wrong standby or reset handling shows in the first control read after the event.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int          CW   = 8,
  parameter int          NTAP = 8,
  parameter logic [7:0]  KEY  = 8'hA5,
  localparam int         SW   = $clog2(NTAP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            standby,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic            bus_sel,
  input  logic [15:0]     bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NTAP-1:0] tap_in,
  output logic            irq_ovf,
  output logic            nmi_req,
  output logic            rst_req
);

  logic [CW-1:0] cnt;
  logic [SW-1:0] cks;
  logic          ovf, mode, run, rsel, armed, tap_q, rst_q;

  wire key_ok  = bus_wr && (bus_wdata[15:8] == KEY);
  wire wr_ctl  = key_ok && !bus_sel;
  wire wr_cnt  = key_ok && bus_sel;
  wire rd_ctl  = bus_rd && !bus_sel;
  wire tap_now = tap_in[cks];
  wire tick    = run && tap_now && !tap_q;
  wire wrap    = tick && (&cnt);
  wire clr_ovf = wr_ctl && armed && !bus_wdata[7];

  wire [7:0] ctl_byte = {ovf, mode, run, rsel, 1'b1, cks};

  assign bus_rdata = bus_sel ? cnt[7:0] : ctl_byte;
  assign irq_ovf   = ovf && !mode;
  assign nmi_req   = ovf && mode && !rsel;
  assign rst_req   = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cks   <= '0;
      ovf   <= 1'b0;
      mode  <= 1'b0;
      run   <= 1'b0;
      rsel  <= 1'b0;
      armed <= 1'b0;
      tap_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      tap_q <= tap_now;
      rst_q <= wrap && mode && rsel && !standby;
      if (standby) begin
        cnt   <= '0;
        ovf   <= 1'b0;
        mode  <= 1'b0;
        run   <= 1'b0;
        rsel  <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (wr_ctl) begin
          mode <= bus_wdata[6];
          run  <= bus_wdata[5];
          rsel <= bus_wdata[4];
          cks  <= bus_wdata[SW-1:0];
        end
        armed <= wr_ctl ? 1'b0 : (armed || (rd_ctl && ovf));
        ovf   <= wrap || (ovf && !clr_ovf);
        if (!run)        cnt <= '0;
        else if (wr_cnt) cnt <= bus_wdata[CW-1:0];
        else if (tick)   cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

module wdt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby,
  input logic       run,
  input logic       ovf,
  input logic       tick,
  input logic [7:0] cnt,
  input logic [2:0] cks,
  input logic       irq_ovf,
  input logic       nmi_req,
  input logic       rst_req
);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == 8'h00));

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 8'hFF && !standby) |=> ovf);

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ovf, nmi_req}));

  // R9
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!ovf && !run && $stable(cks)));

endmodule

bind wdt_timer wdt_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .standby(standby), .run(run), .ovf(ovf),
  .tick(tick), .cnt(cnt), .cks(cks), .irq_ovf(irq_ovf),
  .nmi_req(nmi_req), .rst_req(rst_req)
);

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
  localparam logic [7:0] KEY = 8'hA5;

  logic        clk = 0, rst_n = 0, standby = 0, rd = 0, wr = 0, sel = 0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata, div = '0;
  logic        irq, nmi, rstq;
  logic        sb_on = 0, done = 0;
  int          checks = 0, fails = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) div <= div + 8'd1;

  wdt_timer uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_rd(rd), .bus_wr(wr),
    .bus_sel(sel), .bus_wdata(wdata), .bus_rdata(rdata), .tap_in(div),
    .irq_ovf(irq), .nmi_req(nmi), .rst_req(rstq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd && sb_on) begin
      if (exp_q.size() == 0) check("scoreboard empty", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr_reg(logic s, logic [7:0] key, logic [7:0] d);
    @(posedge clk) #1; sel = s; wdata = {key, d}; wr = 1;
    @(posedge clk) #1; wr = 0;
  endtask

  task automatic rd_exp(logic s, logic [7:0] e, string tag);
    @(posedge clk) #1; sel = s; exp_q.push_back(e); tag_q.push_back(tag);
    sb_on = 1; rd = 1;
    @(posedge clk) #1; rd = 0; sb_on = 0;
  endtask

  task automatic rd_peek(logic s, output logic [7:0] v);
    @(posedge clk) #1; sel = s; rd = 1;
    @(negedge clk) v = rdata;
    @(posedge clk) #1; rd = 0;
  endtask

  task automatic outs(string tag, logic ei, logic en, logic er);
    @(negedge clk);
    check({tag, " irq"}, irq, ei);
    check({tag, " nmi"}, nmi, en);
    check({tag, " rst"}, rstq, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd_exp(0, 8'h08, "R1 control after reset");
    rd_exp(1, 8'h00, "R1 counter after reset");
    outs("R1 outputs after reset", 0, 0, 0);

    wr_reg(0, 8'h00, 8'h3F);
    rd_exp(0, 8'h08, "R2 bad key ignored");
    wr_reg(0, KEY, 8'h21);
    rd_exp(0, 8'h29, "R2 keyed write accepted");

    rd_peek(1, a);
    repeat (62) @(posedge clk);
    rd_exp(1, a + 8'd16, "R4 divide by 4 rate");
    wr_reg(0, KEY, 8'h20);
    rd_peek(1, a);
    repeat (62) @(posedge clk);
    rd_exp(1, a + 8'd32, "R4 divide by 2 rate");

    wr_reg(0, KEY, 8'h00);
    repeat (2) @(posedge clk);
    rd_exp(1, 8'h00, "R5 stopped counter zero");
    repeat (10) @(posedge clk);
    rd_exp(1, 8'h00, "R5 stopped counter holds");
    wr_reg(1, KEY, 8'h55);
    rd_exp(1, 8'h00, "R5 load ignored while stopped");

    wr_reg(0, KEY, 8'h27);
    wr_reg(1, KEY, 8'h40);
    rd_peek(1, v);
    check("R10 counter load", (v == 8'h40 || v == 8'h41), 1);
    wr_reg(1, 8'h5A, 8'h99);
    rd_peek(1, v);
    check("R2 bad key counter write ignored", (v == 8'h40 || v == 8'h41), 1);

    wr_reg(0, KEY, 8'h20);
    wr_reg(1, KEY, 8'hFD);
    repeat (20) @(posedge clk);
    outs("R6 interval overflow", 1, 0, 0);

    wr_reg(0, KEY, 8'h20);
    rd_exp(0, 8'hA8, "R3 write 0 without read keeps flag");
    wr_reg(0, KEY, 8'hA0);
    outs("R3 write 1 has no effect", 1, 0, 0);
    rd_exp(0, 8'hA8, "R3 flag still set");
    wr_reg(0, KEY, 8'h20);
    rd_exp(0, 8'h28, "R3 read then write 0 clears");
    outs("R3 request dropped", 0, 0, 0);

    wr_reg(0, KEY, 8'h60);
    wr_reg(1, KEY, 8'hFD);
    repeat (20) @(posedge clk);
    outs("R7 watchdog nmi", 0, 1, 0);
    rd_exp(0, 8'hE8, "R7 flag set");
    wr_reg(0, KEY, 8'h40);
    outs("R7 nmi cleared", 0, 0, 0);

    wr_reg(0, KEY, 8'h70);
    wr_reg(1, KEY, 8'hFD);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rstq) n++;
      if (nmi || irq) n += 100;
    end
    check("R8 single reset pulse", n, 1);
    rd_exp(0, 8'hF8, "R8 flag set");

    wr_reg(0, KEY, 8'h73);
    @(posedge clk) #1; standby = 1;
    @(posedge clk) #1; standby = 0;
    rd_exp(0, 8'h0B, "R9 standby keeps clock select only");
    rd_exp(1, 8'h00, "R9 standby clears counter");

    @(posedge clk) #1; rst_n = 0;
    @(posedge clk) #1; rst_n = 1;
    rd_exp(0, 8'h08, "R1 reset clears clock select");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule